// File: doc/BRIEF.md
# Timer capture/compare register channel

This block is one channel of a 16-bit timer. It holds two general registers, A and B. Software sets each one, while the timer runs, to act as an output compare register or as an input capture register. In compare mode the register is checked against the free-running counter value on every clock. When they are equal, the register's status flag is set and a pin action may follow. In capture mode a chosen edge on an external input copies the counter value into the register and sets the flag.

A CPU-side bus reads and writes the registers as a full word or as single bytes. The same bus reads the control and status words and clears flags. A PWM-mode input overrides each register's mode setting: both registers then compare, A's match drives pin A high and B's match drives it low. The counter, the prescaler, interrupt routing and full waveform generation sit outside the block.

Top module: `tmr_gr_chan`

## Requirements
- R1: After reset, or on the clock after `stby_i` is high, both general registers read 16'hFFFF, the control word reads 0 (compare mode, no pin action), the status word reads 0, and both pins are 0.
- R2: The bus map is: address 0 is register A, address 1 is register B, address 2 is status (bit0 flag A, bit1 flag B), address 3 is control (bits[2:0] for A, bits[6:4] for B; within each field bit 2 selects capture mode and bits[1:0] are the action or edge code). A write to a general register updates bits[15:8] when `bus_be[1]` is set and bits[7:0] when `bus_be[0]` is set. Control and status writes need `bus_be[0]`. Reads are combinational.
- R3: In compare mode, a cycle in which `cnt_i` equals the register sets that register's flag at the next clock edge. No flag is set while they differ.
- R4: On a compare match the pin changes at the same edge as the flag. Action code 00 leaves the pin unchanged, 01 drives it to 0, 10 drives it to 1 and 11 inverts it.
- R5: In capture mode the capture input passes through a two-flop synchronizer and then an edge detector. Edge code 00 selects rising edges, 01 falling edges, and 1x both. A selected edge loads `cnt_i` into the register and sets the flag on the third clock edge after the input changes. An edge that is not selected changes neither.
- R6: A flag stays at 1 until a status write with 0 in its bit, and only after a status read has returned that bit as 1. A 0 written without such a read, or a 1 written, leaves the flag unchanged.
- R7: If a flag-setting event falls in the same cycle as a valid clear, the flag stays at 1.
- R8: While `pwm_i` is high the control word is ignored. Both registers compare, a match on A drives pin A to 1, a match on B drives pin A to 0, pin B holds, and capture inputs have no effect.
- R9: If a capture and a bus write to the same register fall in the same cycle, the captured counter value is kept.
- R10: In compare mode, edges on the capture input leave the register and its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby: synchronous return to the reset state |
| cnt_i | input | 16 | Free-running counter value |
| pwm_i | input | 1 | PWM mode, overrides the control word |
| cap_a_i | input | 1 | Capture input for register A (asynchronous) |
| cap_b_i | input | 1 | Capture input for register B (asynchronous) |
| bus_addr | input | 2 | Bus address (0 A, 1 B, 2 status, 3 control) |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (arms flag clears) |
| bus_be | input | 2 | Byte enables, bit1 upper byte, bit0 lower byte |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| pin_a_o | output | 1 | Compare output pin for A |
| pin_b_o | output | 1 | Compare output pin for B |
| flag_a_o | output | 1 | Status flag of register A |
| flag_b_o | output | 1 | Status flag of register B |

## Verification
Two pairs of functions can fall in the same cycle. A flag-setting event (a compare match) can meet a software clear of that flag. A capture can meet a bus write to the same register. The bench provokes the first by putting the matching counter value on `cnt_i` in the same cycle as the status write of 0, after a read has armed the clear. It provokes the second by timing the bus write to commit on the third edge after the capture input rises, which is the edge where the synchronized edge loads. It judges both through the bus afterwards: the flag must still read 1, and the register must hold the counter value, not the written data.

// File: rtl/tgr_pkg.sv
`timescale 1ns/1ps
package tgr_pkg;
  localparam int unsigned GR_W = 16;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } pin_act_e;

  // per-register control field: capture select plus action/edge code
  typedef struct packed {
    logic       cap;
    logic [1:0] sel;
  } gr_ctl_t;

  localparam logic [1:0] ADR_GRA  = 2'd0;
  localparam logic [1:0] ADR_GRB  = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
  localparam logic [1:0] ADR_CTL  = 2'd3;
endpackage

// File: rtl/tgr_edge.sv
`timescale 1ns/1ps
module tgr_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       pulse
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              cur, rise, fall;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    cur    = sync_q[STAGES-1];
    prev_d = cur;
    rise   = cur & ~prev_q;
    fall   = ~cur & prev_q;
    if (sel[1])      pulse = rise | fall;
    else if (sel[0]) pulse = fall;
    else             pulse = rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tgr_reg.sv
`timescale 1ns/1ps
module tgr_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stby,
  input  logic [W-1:0] cnt,
  input  logic         cap_mode,
  input  logic         cap_pulse,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [W-1:0] wdata,
  input  logic         stat_rd,
  input  logic         clr0,
  output logic [W-1:0] val,
  output logic         flag,
  output logic         hit
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] val_q, val_d;
  logic         flag_q, flag_d;
  logic         seen_q, seen_d;
  logic         capt, set_ev, val_en;

  always_comb begin
    hit    = ~cap_mode & (cnt == val_q);
    capt   = cap_mode & cap_pulse;
    set_ev = hit | capt;
    val_en = stby | capt | we_lo | we_hi;

    val_d = val_q;
    if (stby) begin
      val_d = '1;
    end else if (capt) begin
      val_d = cnt;
    end else begin
      if (we_hi) val_d[W-1:HALF]  = wdata[W-1:HALF];
      if (we_lo) val_d[HALF-1:0]  = wdata[HALF-1:0];
    end

    flag_d = flag_q;
    if (stby)                 flag_d = 1'b0;
    else if (set_ev)          flag_d = 1'b1;
    else if (clr0 && seen_q)  flag_d = 1'b0;

    seen_d = seen_q;
    if (stby)                 seen_d = 1'b0;
    else if (stat_rd && flag_q) seen_d = 1'b1;
    else if (!flag_d)         seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '1;
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (val_en) val_q <= val_d;
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  assign val  = val_q;
  assign flag = flag_q;
endmodule

// File: rtl/tgr_pin.sv
`timescale 1ns/1ps
module tgr_pin
  import tgr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby,
  input  logic [1:0] act,
  input  logic       hit,
  input  logic       pwm,
  input  logic       pwm_set,
  input  logic       pwm_clr,
  output logic       pin
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (stby) begin
      pin_d = 1'b0;
    end else if (pwm) begin
      if (pwm_clr)      pin_d = 1'b0;
      else if (pwm_set) pin_d = 1'b1;
    end else if (hit) begin
      case (pin_act_e'(act))
        ACT_LOW:  pin_d = 1'b0;
        ACT_HIGH: pin_d = 1'b1;
        ACT_TGL:  pin_d = ~pin_q;
        default:  pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/tmr_gr_chan.sv
`timescale 1ns/1ps
module tmr_gr_chan
  import tgr_pkg::*;
#(
  parameter int unsigned W           = GR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stby_i,
  input  logic [W-1:0] cnt_i,
  input  logic         pwm_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_be,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pin_a_o,
  output logic         pin_b_o,
  output logic         flag_a_o,
  output logic         flag_b_o
);
  localparam int unsigned NREG = 2;
  localparam int unsigned CW   = $bits(gr_ctl_t);

  gr_ctl_t [NREG-1:0]         ctl_q, ctl_d;
  logic    [NREG-1:0][W-1:0]  gr_val;
  logic    [NREG-1:0]         flag, hit, cap_in, cap_pls, cap_eff, pin;
  logic    [NREG-1:0]         gr_we, pwm_set, pwm_clr;
  logic                       ctl_we, ctl_en, stat_rd, stat_clr;
  logic    [W-1:0]            gr_a, gr_b;
  logic                       cap_a_eff, cap_b_eff;

  assign cap_in   = {cap_b_i, cap_a_i};
  assign ctl_we   = bus_wr & (bus_addr == ADR_CTL) & bus_be[0];
  assign ctl_en   = ctl_we | stby_i;
  assign stat_rd  = bus_rd & (bus_addr == ADR_STAT);
  assign stat_clr = bus_wr & (bus_addr == ADR_STAT) & bus_be[0];

  always_comb begin
    ctl_d = ctl_q;
    if (stby_i) begin
      ctl_d = '0;
    end else if (ctl_we) begin
      ctl_d[0] = gr_ctl_t'(bus_wdata[CW-1:0]);
      ctl_d[1] = gr_ctl_t'(bus_wdata[4+CW-1:4]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_gr
    assign cap_eff[i] = ctl_q[i].cap & ~pwm_i;
    assign gr_we[i]   = bus_wr & (bus_addr == 2'(i));
    if (i == 0) begin : g_pwm_lead
      assign pwm_set[i] = hit[0];
      assign pwm_clr[i] = hit[1];
    end else begin : g_pwm_none
      assign pwm_set[i] = 1'b0;
      assign pwm_clr[i] = 1'b0;
    end

    tgr_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_in[i]),
      .sel   (ctl_q[i].sel),
      .pulse (cap_pls[i])
    );

    tgr_reg #(.W(W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby      (stby_i),
      .cnt       (cnt_i),
      .cap_mode  (cap_eff[i]),
      .cap_pulse (cap_pls[i]),
      .we_lo     (gr_we[i] & bus_be[0]),
      .we_hi     (gr_we[i] & bus_be[1]),
      .wdata     (bus_wdata),
      .stat_rd   (stat_rd),
      .clr0      (stat_clr & ~bus_wdata[i]),
      .val       (gr_val[i]),
      .flag      (flag[i]),
      .hit       (hit[i])
    );

    tgr_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .stby    (stby_i),
      .act     (ctl_q[i].sel),
      .hit     (hit[i]),
      .pwm     (pwm_i),
      .pwm_set (pwm_set[i]),
      .pwm_clr (pwm_clr[i]),
      .pin     (pin[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_GRA:  bus_rdata = gr_val[0];
      ADR_GRB:  bus_rdata = gr_val[1];
      ADR_STAT: bus_rdata[NREG-1:0] = flag;
      default: begin
        bus_rdata[CW-1:0]   = ctl_q[0];
        bus_rdata[4+CW-1:4] = ctl_q[1];
      end
    endcase
  end

  assign gr_a      = gr_val[0];
  assign gr_b      = gr_val[1];
  assign cap_a_eff = cap_eff[0];
  assign cap_b_eff = cap_eff[1];
  assign pin_a_o   = pin[0];
  assign pin_b_o   = pin[1];
  assign flag_a_o  = flag[0];
  assign flag_b_o  = flag[1];
endmodule

// File: rtl/tgr_chk.sv
`timescale 1ns/1ps
module tgr_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stby_i,
  input logic         pwm_i,
  input logic [W-1:0] cnt_i,
  input logic         bus_wr,
  input logic [W-1:0] gr_a,
  input logic [W-1:0] gr_b,
  input logic         cap_a_eff,
  input logic         cap_b_eff,
  input logic         flag_a_o,
  input logic         flag_b_o,
  input logic         pin_a_o
);
  // R1
  stby_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |=> (gr_a == '1) && (gr_b == '1) && !flag_a_o && !flag_b_o && !pin_a_o);

  // R3
  cmp_flag_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_a_eff && (cnt_i == gr_a) && !stby_i) |=> flag_a_o);

  // R3
  cmp_flag_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_b_eff && (cnt_i == gr_b) && !stby_i) |=> flag_b_o);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a_o && !bus_wr && !stby_i) |=> flag_a_o);

  // R8
  pwm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_i && (cnt_i == gr_a) && (cnt_i != gr_b) && !stby_i) |=> pin_a_o);

  // R8
  pwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_i && (cnt_i == gr_b) && !stby_i) |=> !pin_a_o);

  // R10
  gr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !cap_a_eff && !stby_i) |=> $stable(gr_a));
endmodule

bind tmr_gr_chan tgr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stby_i    (stby_i),
  .pwm_i     (pwm_i),
  .cnt_i     (cnt_i),
  .bus_wr    (bus_wr),
  .gr_a      (gr_a),
  .gr_b      (gr_b),
  .cap_a_eff (cap_a_eff),
  .cap_b_eff (cap_b_eff),
  .flag_a_o  (flag_a_o),
  .flag_b_o  (flag_b_o),
  .pin_a_o   (pin_a_o)
);

// File: tb/sim_tmr_gr_chan.sv
`timescale 1ns/1ps
module sim_tmr_gr_chan;
  localparam real CLK_P = 5.0;
  localparam logic [15:0] IDLE = 16'h0F0F;

  logic        clk, rst_n, stby_i, pwm_i, cap_a_i, cap_b_i;
  logic [15:0] cnt_i, bus_wdata, bus_rdata;
  logic [1:0]  bus_addr, bus_be;
  logic        bus_wr, bus_rd;
  logic        pin_a_o, pin_b_o, flag_a_o, flag_b_o;
  int          total, bad;
  logic        done;
  logic [15:0] rv;

  tmr_gr_chan u0 (
    .clk(clk), .rst_n(rst_n), .stby_i(stby_i), .cnt_i(cnt_i), .pwm_i(pwm_i),
    .cap_a_i(cap_a_i), .cap_b_i(cap_b_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_a_o(pin_a_o), .pin_b_o(pin_b_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_w(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_r(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cnt_pulse(input logic [15:0] v);
    @(negedge clk);
    cnt_i = v;
    @(negedge clk);
    cnt_i = IDLE;
    #1;
  endtask

  task automatic set_cap(input logic a, input logic v);
    @(negedge clk);
    if (a) cap_a_i = v; else cap_b_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    bus_r(ADR_A(), rv); chk("R1 A reset", rv, 16'hFFFF);
    bus_r(2'd1, rv);    chk("R1 B reset", rv, 16'hFFFF);
    bus_r(2'd2, rv);    chk("R1 status reset", rv, 16'h0000);
    bus_r(2'd3, rv);    chk("R1 control reset", rv, 16'h0000);
    chk("R1 pins reset", {14'b0, pin_b_o, pin_a_o}, 16'h0000);
  endtask

  function automatic logic [1:0] ADR_A();
    return 2'd0;
  endfunction

  task automatic t_bus;
    bus_w(2'd0, 2'b11, 16'h1234); bus_r(2'd0, rv); chk("R2 word write", rv, 16'h1234);
    bus_w(2'd0, 2'b10, 16'hAB00); bus_r(2'd0, rv); chk("R2 upper byte", rv, 16'hAB34);
    bus_w(2'd1, 2'b01, 16'h0055); bus_r(2'd1, rv); chk("R2 lower byte", rv, 16'hFF55);
    bus_w(2'd1, 2'b00, 16'h0000); bus_r(2'd1, rv); chk("R2 no lane", rv, 16'hFF55);
  endtask

  task automatic t_cmp;
    bus_w(2'd3, 2'b01, 16'h0032);           // A high, B toggle
    bus_w(2'd0, 2'b11, 16'h0100);
    chk("R3 no match no flag", {14'b0, flag_b_o, flag_a_o}, 16'h0000);
    cnt_pulse(16'h0100);
    chk("R3 flag A set", {15'b0, flag_a_o}, 16'h0001);
    chk("R3 flag B clear", {15'b0, flag_b_o}, 16'h0000);
    chk("R4 high action", {15'b0, pin_a_o}, 16'h0001);
    cnt_pulse(16'hFF55);
    chk("R3 flag B set", {15'b0, flag_b_o}, 16'h0001);
    chk("R4 toggle to 1", {15'b0, pin_b_o}, 16'h0001);
    cnt_pulse(16'hFF55);
    chk("R4 toggle to 0", {15'b0, pin_b_o}, 16'h0000);
    bus_w(2'd3, 2'b01, 16'h0030);           // A no action
    cnt_pulse(16'h0100);
    chk("R4 none action", {15'b0, pin_a_o}, 16'h0001);
    bus_w(2'd3, 2'b01, 16'h0031);           // A low
    cnt_pulse(16'h0100);
    chk("R4 low action", {15'b0, pin_a_o}, 16'h0000);
  endtask

  task automatic t_clr;
    bus_w(2'd2, 2'b01, 16'h0000);
    bus_r(2'd2, rv); chk("R6 clear without read", rv, 16'h0003);
    bus_w(2'd2, 2'b01, 16'h0002);
    bus_r(2'd2, rv); chk("R6 write 1 keeps B", rv, 16'h0002);
    bus_w(2'd2, 2'b01, 16'h0000);
    bus_r(2'd2, rv); chk("R6 armed clear", rv, 16'h0000);
  endtask

  task automatic t_race;
    cnt_pulse(16'h0100);
    bus_r(2'd2, rv); chk("R7 flag before race", rv, 16'h0001);
    @(negedge clk);
    bus_addr = 2'd2; bus_be = 2'b01; bus_wdata = 16'h0000; bus_wr = 1'b1;
    cnt_i = 16'h0100;
    @(negedge clk);
    bus_wr = 1'b0; cnt_i = IDLE;
    bus_r(2'd2, rv); chk("R7 event beats clear", rv, 16'h0001);
    bus_w(2'd2, 2'b01, 16'h0000);
    bus_r(2'd2, rv); chk("R6 clear after race", rv, 16'h0000);
  endtask

  task automatic t_cap;
    bus_w(2'd3, 2'b01, 16'h0034);           // A capture rising, B compare toggle
    @(negedge clk); cnt_i = 16'h4321;
    set_cap(1'b1, 1'b1);
    bus_r(2'd0, rv); chk("R5 rising capture", rv, 16'h4321);
    bus_r(2'd2, rv); chk("R5 capture flag", rv, 16'h0001);
    bus_w(2'd2, 2'b01, 16'h0000);
    @(negedge clk); cnt_i = 16'h5555;
    set_cap(1'b1, 1'b0);
    bus_r(2'd0, rv); chk("R5 falling ignored in rising", rv, 16'h4321);
    bus_r(2'd2, rv); chk("R5 no flag unselected", rv, 16'h0000);
    bus_w(2'd3, 2'b01, 16'h0035);           // falling
    @(negedge clk); cnt_i = 16'h6666;
    set_cap(1'b1, 1'b1);
    bus_r(2'd0, rv); chk("R5 rising ignored in falling", rv, 16'h4321);
    set_cap(1'b1, 1'b0);
    bus_r(2'd0, rv); chk("R5 falling capture", rv, 16'h6666);
    bus_w(2'd3, 2'b01, 16'h0036);           // both
    @(negedge clk); cnt_i = 16'h7070;
    set_cap(1'b1, 1'b1);
    bus_r(2'd0, rv); chk("R5 both rising", rv, 16'h7070);
    @(negedge clk); cnt_i = 16'h7171;
    set_cap(1'b1, 1'b0);
    bus_r(2'd0, rv); chk("R5 both falling", rv, 16'h7171);
    bus_w(2'd2, 2'b01, 16'h0000);
    bus_r(2'd2, rv);
    bus_w(2'd2, 2'b01, 16'h0000);
  endtask

  task automatic t_cap_race;
    bus_w(2'd3, 2'b01, 16'h0034);
    @(negedge clk); cnt_i = 16'h7777; cap_a_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd0; bus_be = 2'b11; bus_wdata = 16'h1111; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_r(2'd0, rv); chk("R9 capture beats write", rv, 16'h7777);
  endtask

  task automatic t_ignore;
    @(negedge clk); cnt_i = 16'h2222;
    set_cap(1'b0, 1'b1);
    set_cap(1'b0, 1'b0);
    bus_r(2'd1, rv); chk("R10 compare ignores capture", rv, 16'hFF55);
    chk("R10 no flag from capture", {15'b0, flag_b_o}, 16'h0000);
  endtask

  task automatic t_pwm;
    @(negedge clk); cnt_i = IDLE; pwm_i = 1'b1;
    bus_w(2'd0, 2'b11, 16'h0010);
    bus_w(2'd1, 2'b11, 16'h0020);
    cnt_pulse(16'h0010);
    chk("R8 A match sets pin", {15'b0, pin_a_o}, 16'h0001);
    chk("R8 A flag in pwm", {15'b0, flag_a_o}, 16'h0001);
    set_cap(1'b1, 1'b0);
    bus_r(2'd0, rv); chk("R8 capture ignored", rv, 16'h0010);
    cnt_pulse(16'h0020);
    chk("R8 B match clears pin", {15'b0, pin_a_o}, 16'h0000);
    chk("R8 pin B holds", {15'b0, pin_b_o}, 16'h0000);
  endtask

  task automatic t_stby;
    cnt_pulse(16'h0010);
    chk("R8 pin high before standby", {15'b0, pin_a_o}, 16'h0001);
    @(negedge clk); stby_i = 1'b1;
    @(negedge clk); stby_i = 1'b0; pwm_i = 1'b0;
    bus_r(2'd0, rv); chk("R1 standby A", rv, 16'hFFFF);
    bus_r(2'd1, rv); chk("R1 standby B", rv, 16'hFFFF);
    bus_r(2'd2, rv); chk("R1 standby status", rv, 16'h0000);
    bus_r(2'd3, rv); chk("R1 standby control", rv, 16'h0000);
    chk("R1 standby pin", {15'b0, pin_a_o}, 16'h0000);
  endtask

  localparam logic [1:0] ADR_GRA_TB = 2'd0;

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; stby_i = 1'b0; pwm_i = 1'b0; cap_a_i = 1'b0; cap_b_i = 1'b0;
    cnt_i = IDLE; bus_addr = ADR_GRA_TB; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_be = 2'b00; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bus();
    t_cmp();
    t_clr();
    t_race();
    t_cap();
    t_cap_race();
    t_ignore();
    t_pwm();
    t_stby();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule